// File: doc/BRIEF.md
# Iterative Bit Scan, Bit Test and Byte Swap Unit

This unit executes single-operand bit manipulation operations for an integer datapath. A requester presents an operand, a bit index, an operation code and a width select together with a one-cycle `start` pulse. The unit answers with a destination value, a bit position, a zero flag and a carry flag. A one-cycle `done` pulse marks the moment these outputs are valid.

Searches for a set bit walk the operand one position per clock. They run from the low end upward or from the top position downward. Their latency therefore depends on where the first set bit sits. Bit tests read one addressed bit into the carry flag and may also invert, clear or set that bit in the destination. The byte swap reverses the four bytes of a full-width word. The non-scan operations all finish one cycle after they are accepted. The unit holds its outputs between operations, so a scan that finds nothing leaves the previous position in place.

Top module: `bitscan_unit`

## Requirements
- R1: After reset, `result`, `index`, `zf`, `cf`, `done` and `busy` are all zero.
- R2: Operation code 0 (ascending scan) finds the lowest set bit p. It sets `zf`, loads `index` with p and `result` with p zero-extended. `done` is high after the p+2-th rising edge counted from the edge that samples `start`, which counts as edge 1.
- R3: Operation code 1 (descending scan) finds the highest set bit p below the top position T (T = 31 when `wide`=1, 15 when `wide`=0). It gives the same outputs as R2, with `done` high after edge T-p+2.
- R4: A scan of an operand with no set bit in range clears `zf` and leaves `index` and `result` at their previous values. Its `done` is high after edge 33 when `wide`=1 and after edge 17 when `wide`=0.
- R5: With `wide`=0, operand bits 31:16 are ignored by every operation. A bit index is taken modulo 16 there (bit 4 of `bit_idx` is ignored) and modulo 32 when `wide`=1.
- R6: Operation code 2 (test) copies the addressed bit into `cf`. It writes the operand to `result`, with bits 31:16 zero when `wide`=0, and leaves `zf` unchanged.
- R7: Operation codes 3, 4 and 5 copy the original addressed bit into `cf`. They write the operand to `result` with that bit inverted (3), cleared (4) or set (5). `zf` is left unchanged.
- R8: Operation code 6 writes the byte-reversed operand to `result` when `wide`=1 and zero when `wide`=0. It leaves `zf`, `cf` and `index` unchanged.
- R9: Operation codes 2 to 7 raise `done` after edge 1. Code 7 changes no output other than `done`.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The scan in progress finishes with its own result and timing.
- R11: Scans never change `cf`. `zf`, `cf` and `index` change only in a cycle where `done` is high, and `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when `busy` is low |
| op | input | 3 | Operation code (see R2 to R9) |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| operand | input | 32 | Source value |
| bit_idx | input | 5 | Addressed bit for test operations |
| result | output | 32 | Destination value |
| index | output | 5 | Position reported by the last successful scan |
| zf | output | 1 | Zero flag, written by scans |
| cf | output | 1 | Carry flag, written by bit tests |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A scan is in progress |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `op`, `wide`, `operand` and `bit_idx` are valid in the cycle `start` is high. They assume that once a scan is accepted, the requester waits for `done` before relying on the outputs. The directed stimulus drives inputs only on falling edges and holds `start` for exactly one cycle per operation. It waits for `done` before the next operation, except in the scenario that deliberately pulses `start` during a running scan to exercise R10.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    OP_SCAN_UP   = 3'd0,
    OP_SCAN_DOWN = 3'd1,
    OP_TEST      = 3'd2,
    OP_FLIP      = 3'd3,
    OP_CLEAR     = 3'd4,
    OP_MARK      = 3'd5,
    OP_SWAP      = 3'd6,
    OP_IDLE      = 3'd7
  } bsu_op_e;

  function automatic logic is_scan(input logic [2:0] code);
    return (code == OP_SCAN_UP) || (code == OP_SCAN_DOWN);
  endfunction

  function automatic logic is_bit_op(input logic [2:0] code);
    return (code == OP_TEST) || (code == OP_FLIP) ||
           (code == OP_CLEAR) || (code == OP_MARK);
  endfunction
endpackage

// File: rtl/bsu_scan_engine.sv
module bsu_scan_engine #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              descend,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd,
  output logic              busy,
  output logic              hit,
  output logic              exhaust,
  output logic [IDX_W-1:0]  pos
);
  localparam logic [IDX_W-1:0] TOP_WIDE   = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] TOP_NARROW = IDX_W'(HALF_W - 1);

  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  pos_q;
  logic [IDX_W-1:0]  stop_q;
  logic              down_q;
  logic              busy_q;
  logic [IDX_W-1:0]  top_pos;
  logic              cur_bit;

  assign top_pos = wide ? TOP_WIDE : TOP_NARROW;
  assign cur_bit = data_q[pos_q];
  assign hit     = busy_q & cur_bit;
  assign exhaust = busy_q & ~cur_bit & (pos_q == stop_q);
  assign busy    = busy_q;
  assign pos     = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pos_q  <= '0;
      stop_q <= '0;
      down_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (load) begin
      data_q <= wide ? opnd : {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};
      pos_q  <= descend ? top_pos : '0;
      stop_q <= descend ? '0 : top_pos;
      down_q <= descend;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (hit || exhaust) begin
        busy_q <= 1'b0;
      end else begin
        pos_q <= down_q ? pos_q - IDX_W'(1) : pos_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/bsu_bit_op.sv
module bsu_bit_op #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] res,
  output logic              picked
);
  import bsu_pkg::*;

  logic [IDX_W-1:0]  eff_idx;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] sel_mask;

  assign eff_idx  = wide ? idx : {1'b0, idx[IDX_W-2:0]};
  assign base     = wide ? opnd : {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};
  assign sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << eff_idx;
  assign picked   = base[eff_idx];

  always_comb begin
    case (op)
      OP_FLIP:  res = base ^ sel_mask;
      OP_CLEAR: res = base & ~sel_mask;
      OP_MARK:  res = base | sel_mask;
      default:  res = base;
    endcase
  end
endmodule

// File: rtl/bsu_byte_swap.sv
module bsu_byte_swap #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] swapped;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign swapped[8*b +: 8] = opnd[DATA_W - 8 - 8*b +: 8];
  end

  assign res = wide ? swapped : '0;
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  index,
  output logic              zf,
  output logic              cf,
  output logic              done,
  output logic              busy
);
  import bsu_pkg::*;

  logic              accept;
  logic              scan_go;
  logic              scan_hit;
  logic              scan_exhaust;
  logic [IDX_W-1:0]  scan_pos;
  logic [DATA_W-1:0] bit_res;
  logic              bit_picked;
  logic [DATA_W-1:0] swap_res;

  assign accept  = start & ~busy;
  assign scan_go = accept & is_scan(op);

  bsu_scan_engine #(.DATA_W(DATA_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (scan_go),
    .descend (op == OP_SCAN_DOWN),
    .wide    (wide),
    .opnd    (operand),
    .busy    (busy),
    .hit     (scan_hit),
    .exhaust (scan_exhaust),
    .pos     (scan_pos)
  );

  bsu_bit_op #(.DATA_W(DATA_W)) u_bit (
    .op     (op),
    .wide   (wide),
    .opnd   (operand),
    .idx    (bit_idx),
    .res    (bit_res),
    .picked (bit_picked)
  );

  bsu_byte_swap #(.DATA_W(DATA_W)) u_swap (
    .wide (wide),
    .opnd (operand),
    .res  (swap_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      index  <= '0;
      zf     <= 1'b0;
      cf     <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && !is_scan(op)) begin
        done <= 1'b1;
        if (is_bit_op(op)) begin
          result <= bit_res;
          cf     <= bit_picked;
        end else if (op == OP_SWAP) begin
          result <= swap_res;
        end
      end
      if (scan_hit) begin
        done   <= 1'b1;
        zf     <= 1'b1;
        index  <= scan_pos;
        result <= DATA_W'(scan_pos);
      end else if (scan_exhaust) begin
        done <= 1'b1;
        zf   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic             busy,
  input logic             done,
  input logic             zf,
  input logic             cf,
  input logic [IDX_W-1:0] index,
  input logic             scan_hit,
  input logic             scan_exhaust
);
  p_single_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_hit, scan_exhaust}));

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_scan_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op == 3'd0 || op == 3'd1)) |=> busy);

  p_zf_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zf) |-> done);

  p_cf_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cf) |-> done);

  p_index_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(index) |-> (done && zf));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_hit && !scan_exhaust) |=> busy);
endmodule

bind bitscan_unit bsu_checker #(.DATA_W(DATA_W)) u_bsu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .op           (op),
  .busy         (busy),
  .done         (done),
  .zf           (zf),
  .cf           (cf),
  .index        (index),
  .scan_hit     (scan_hit),
  .scan_exhaust (scan_exhaust)
);

// File: tb/test_bitscan_unit.sv
`timescale 1ns/1ps
module test_bitscan_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b1;
  logic [31:0] operand = '0;
  logic [4:0]  bit_idx = '0;
  logic [31:0] result;
  logic [4:0]  index;
  logic        zf, cf, done, busy;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bitscan_unit i_bitscan_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .operand(operand), .bit_idx(bit_idx), .result(result), .index(index),
    .zf(zf), .cf(cf), .done(done), .busy(busy)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  // Lowest set bit in range, or -1
  function automatic int low_bit(input logic [31:0] v, input int w);
    for (int i = 0; i < w; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int high_bit(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  // Issue one operation and count edges until done (edge sampling start = 1)
  task automatic issue(input logic [2:0] c, input logic w, input logic [31:0] v,
                       input logic [4:0] bi, output int lat);
    @(negedge clk);
    op = c; wide = w; operand = v; bit_idx = bi; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    if (lat >= 100) begin
      fails++;
      $display("FAIL watchdog: no done for op %0d", c);
    end
  endtask

  task automatic t_reset();
    chk("R1", "result", result, 0);
    chk("R1", "index", {27'd0, index}, 0);
    chk("R1", "zf", {31'd0, zf}, 0);
    chk("R1", "cf", {31'd0, cf}, 0);
    chk("R1", "done", {31'd0, done}, 0);
    chk("R1", "busy", {31'd0, busy}, 0);
  endtask

  task automatic t_scan_up();
    logic [31:0] pats [4] = '{32'h0000_0001, 32'h8000_0000, 32'h00F0_0100, 32'hFFFF_FFF0};
    int lat, p;
    foreach (pats[k]) begin
      p = low_bit(pats[k], 32);
      issue(3'd0, 1'b1, pats[k], 5'd0, lat);
      chk("R2", "index", {27'd0, index}, p);
      chk("R2", "result", result, p);
      chk("R2", "zf", {31'd0, zf}, 1);
      chk("R2", "latency", lat, p + 2);
    end
  endtask

  task automatic t_scan_down();
    logic [31:0] pats [3] = '{32'h8000_0000, 32'h0000_0001, 32'h00F0_0100};
    int lat, p;
    foreach (pats[k]) begin
      p = high_bit(pats[k], 32);
      issue(3'd1, 1'b1, pats[k], 5'd0, lat);
      chk("R3", "index", {27'd0, index}, p);
      chk("R3", "result", result, p);
      chk("R3", "latency", lat, 31 - p + 2);
    end
    issue(3'd1, 1'b0, 32'h1234_0400, 5'd0, lat);
    chk("R3", "narrow index", {27'd0, index}, 10);
    chk("R3", "narrow latency", lat, 15 - 10 + 2);
  endtask

  task automatic t_no_bit();
    int lat;
    issue(3'd0, 1'b1, 32'h0000_0020, 5'd0, lat);
    chk("R4", "setup index", {27'd0, index}, 5);
    issue(3'd0, 1'b1, 32'h0, 5'd0, lat);
    chk("R4", "zf cleared", {31'd0, zf}, 0);
    chk("R4", "index held", {27'd0, index}, 5);
    chk("R4", "result held", result, 5);
    chk("R4", "wide latency", lat, 33);
    issue(3'd1, 1'b0, 32'h0, 5'd0, lat);
    chk("R4", "narrow latency", lat, 17);
  endtask

  task automatic t_narrow();
    int lat;
    issue(3'd0, 1'b1, 32'h0000_0100, 5'd0, lat);
    issue(3'd0, 1'b0, 32'hFFFF_0000, 5'd0, lat);
    chk("R5", "upper half ignored zf", {31'd0, zf}, 0);
    chk("R5", "upper half ignored index", {27'd0, index}, 8);
    chk("R5", "latency", lat, 17);
    issue(3'd2, 1'b0, 32'hFFFF_0010, 5'd20, lat);
    chk("R5", "index modulo 16 cf", {31'd0, cf}, 1);
    chk("R5", "narrow result", result, 32'h0000_0010);
  endtask

  task automatic t_bit_test();
    int lat;
    issue(3'd0, 1'b1, 32'h0000_0004, 5'd0, lat);   // zf = 1
    issue(3'd2, 1'b1, 32'hA5, 5'd0, lat);
    chk("R6", "cf bit0", {31'd0, cf}, 1);
    chk("R6", "result", result, 32'hA5);
    chk("R6", "zf unchanged", {31'd0, zf}, 1);
    chk("R9", "test latency", lat, 1);
    issue(3'd2, 1'b1, 32'hA5, 5'd1, lat);
    chk("R6", "cf bit1", {31'd0, cf}, 0);
    issue(3'd2, 1'b1, 32'h8000_0000, 5'd31, lat);
    chk("R6", "cf bit31", {31'd0, cf}, 1);
  endtask

  task automatic t_modify();
    int lat;
    issue(3'd3, 1'b1, 32'h0F, 5'd3, lat);
    chk("R7", "flip result", result, 32'h07);
    chk("R7", "flip cf", {31'd0, cf}, 1);
    chk("R9", "flip latency", lat, 1);
    issue(3'd4, 1'b1, 32'hF0, 5'd4, lat);
    chk("R7", "clear result", result, 32'hE0);
    chk("R7", "clear cf", {31'd0, cf}, 1);
    issue(3'd5, 1'b1, 32'h0, 5'd31, lat);
    chk("R7", "mark result", result, 32'h8000_0000);
    chk("R7", "mark cf", {31'd0, cf}, 0);
    chk("R7", "zf unchanged", {31'd0, zf}, 1);
  endtask

  task automatic t_swap();
    int lat;
    logic save_cf, save_zf;
    logic [4:0] save_idx;
    save_cf = cf; save_zf = zf; save_idx = index;
    issue(3'd6, 1'b1, 32'h1122_3344, 5'd0, lat);
    chk("R8", "wide swap", result, 32'h4433_2211);
    chk("R9", "swap latency", lat, 1);
    chk("R8", "cf kept", {31'd0, cf}, {31'd0, save_cf});
    chk("R8", "zf kept", {31'd0, zf}, {31'd0, save_zf});
    chk("R8", "index kept", {27'd0, index}, {27'd0, save_idx});
    issue(3'd6, 1'b0, 32'h1122_3344, 5'd0, lat);
    chk("R8", "narrow swap zero", result, 0);
    issue(3'd6, 1'b1, 32'hDEAD_BEEF, 5'd0, lat);
    issue(3'd7, 1'b1, 32'h0, 5'd9, lat);
    chk("R9", "idle keeps result", result, 32'hEFBE_ADDE);
    chk("R9", "idle latency", lat, 1);
  endtask

  task automatic t_busy_ignore();
    int lat;
    logic save_cf;
    issue(3'd5, 1'b1, 32'h0, 5'd0, lat);   // cf = 0
    save_cf = cf;
    @(negedge clk);
    op = 3'd0; wide = 1'b1; operand = 32'h8000_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (2) begin @(posedge clk); @(negedge clk); lat++; end
    op = 3'd6; operand = 32'h0102_0304; start = 1'b1;
    @(posedge clk); @(negedge clk); lat++;
    start = 1'b0;
    chk("R10", "done after ignored start", {31'd0, done}, 0);
    while (!done && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
    chk("R10", "scan latency kept", lat, 33);
    chk("R10", "scan result kept", result, 31);
    chk("R11", "cf untouched by scan", {31'd0, cf}, {31'd0, save_cf});
    @(posedge clk); @(negedge clk);
    chk("R11", "done single pulse", {31'd0, done}, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_scan_up();
    t_scan_down();
    t_no_bit();
    t_narrow();
    t_bit_test();
    t_modify();
    t_swap();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule